// File: doc/BRIEF.md
# Tuning Synthesizer Serial Register Interface

This block is the two-wire serial slave that sets up a frequency synthesizer. Everything runs in the system clock domain. The block oversamples the serial clock and data lines and finds start and stop conditions. It matches the device address and accepts data bytes with auto-increment. The most significant bit of the first data byte chooses the path:

- 0 steers the sequence into the divider path (high divider byte, then low divider byte).
- 1 steers it into the control path (control byte, then port byte).

Each register takes its new value only at the clock edge that ends the last byte belonging to it. A bus master can therefore reprogram one part of the synthesizer without touching the other parts.

In read mode the block returns one status byte. That byte carries a power-on flag, the loop lock flag and a three-bit converter code. The power-on flag clears once it has been read. The serial data line is open-drain: the block drives an enable that pulls the line low and never drives it high.

Top module: `synth_i2c_regif`

## Requirements
- R1: The block acknowledges a matching address byte and every write data byte by asserting `sda_oe` during the ninth clock of that byte.
- R2: When the first data byte after an address has bit 7 = 0, its bits 6..0 are divider bits 14..8. The next byte holds divider bits 7..0. `freq_word` updates only when the clock edge ending the 8th bit of that second byte arrives.
- R3: When the first data byte has bit 7 = 1, it is the control byte, laid out as {1, pump, test[2:0], ref[1:0], tune_off}. Its fields update at the end of its 8th bit, and the byte after it is the port byte.
- R4: A high divider byte alone leaves `freq_word` unchanged. After the low divider byte, the next byte is decoded as a control byte from its bits 6..0, and the byte after that as a port byte.
- R5: The port byte drives `port_out[7:0]`. Bit 3 has no effect and `port_out[3]` stays 0.
- R6: The address byte is {11000, MA1, MA0, R/W}. `addr_sel` values 00, 01, 10 and 11 give MA values 01, 10, 11 and 01. MA = 01 (0xC2 for write, 0xC3 for read) is always accepted. Any other address is not acknowledged and changes nothing.
- R7: After reset:
  - `freq_word` = 0
  - `pump_high` = 0
  - `test_mode` = 001
  - `ref_ratio` = 00
  - `tune_off` = 0
  - `port_out` = 0
  - `sda_oe` = 0
- R8: After the port byte, further write bytes are acknowledged but ignored until a stop or a repeated start.
- R9: A read returns one byte, MSB first: {POR, lock, 1, 1, 0, adc[2:0]}. The byte is captured when the address is acknowledged.
- R10: POR reads 1 after reset. It becomes 0 once a status byte has been fully sent, and stays 0.
- R11: An `adc_code` value above 4 is reported as 4.
- R12: A repeated start restarts the byte sequence, so the next data byte is decoded by its bit 7 again. A high divider byte that arrived before the repeated start is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | Pull the data line low when 1 |
| addr_sel | input | 2 | Selects address bits MA1..MA0 |
| lock_i | input | 1 | Loop lock flag |
| adc_code | input | 3 | Converter level, 0..4 valid |
| freq_word | output | DIV_W | Programmable divider ratio |
| pump_high | output | 1 | High charge-pump current select |
| test_mode | output | 3 | Test bits |
| ref_ratio | output | 2 | Reference divider select |
| tune_off | output | 1 | Tuning output disable |
| port_out | output | 8 | Band switch and port controls |

## Verification
The bench builds the block with its defaults: a two-stage line synchronizer and a 15-bit divider. It runs the bus with eight system clocks per quarter bit, which leaves room for the synchronizer and edge detection before each serial clock edge. The runs cover:

- both steering paths, including partial programming, repeated starts and bytes sent past the port byte;
- the general address under two different select codes;
- two consecutive reads, which show the power-on flag clearing and the converter clamp.

// File: rtl/synth_i2c_pkg.sv
package synth_i2c_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam logic [4:0] ADDR_FIXED = 5'b11000;
    localparam logic [1:0] MA_GENERAL = 2'b01;
    localparam logic [2:0] ADC_MAX = 3'd4;
    localparam logic [BYTE_W-1:0] PORT_MASK = 8'hF7;

    typedef enum logic [2:0] {
        BUS_IDLE, BUS_ADDR, BUS_ADDR_ACK, BUS_WR, BUS_WR_ACK, BUS_RD, BUS_RD_ACK
    } bus_state_e;

    typedef enum logic [2:0] {
        SEQ_FIRST, SEQ_DB2, SEQ_CB, SEQ_PB, SEQ_DONE
    } seq_state_e;

    typedef struct packed {
        logic       pump_high;
        logic [2:0] test;
        logic [1:0] ref_ratio;
        logic       tune_off;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{pump_high: 1'b0, test: 3'b001, ref_ratio: 2'b00, tune_off: 1'b0};

    function automatic logic [1:0] ma_from_sel(input logic [1:0] sel);
        case (sel)
            2'b00:   return 2'b01;
            2'b01:   return 2'b10;
            2'b10:   return 2'b11;
            default: return MA_GENERAL;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] make_status(input logic por, input logic fl,
                                                      input logic [2:0] adc);
        logic [2:0] lvl;
        lvl = (adc > ADC_MAX) ? ADC_MAX : adc;
        return {por, fl, 3'b110, lvl};
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic scl_d, sda_d, scl_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_d  <= scl_sh[STAGES-1];
            sda_d  <= sda_sh[STAGES-1];
        end
    end

    assign scl_s     = scl_sh[STAGES-1];
    assign sda_s     = sda_sh[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign bus_start = scl_s & scl_d & sda_d & ~sda_s;
    assign bus_stop  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
    import synth_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic [1:0]        addr_sel,
    input  logic [BYTE_W-1:0] status,
    output logic              sda_oe,
    output logic              wr_valid,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              rd_done
);
    bus_state_e        state;
    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] shreg, tx_q;
    logic              rw_q;
    logic              addr_hit;

    assign addr_hit = (shreg[7:1] == {ADDR_FIXED, ma_from_sel(addr_sel)}) ||
                      (shreg[7:1] == {ADDR_FIXED, MA_GENERAL});

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= BUS_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            tx_q     <= '0;
            rw_q     <= 1'b0;
            sda_oe   <= 1'b0;
            wr_valid <= 1'b0;
            wr_byte  <= '0;
            rd_done  <= 1'b0;
        end else begin
            wr_valid <= 1'b0;
            rd_done  <= 1'b0;
            if (bus_start) begin
                state  <= BUS_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (bus_stop) begin
                state  <= BUS_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    BUS_ADDR, BUS_WR: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            if (state == BUS_WR) begin
                                state    <= BUS_WR_ACK;
                                sda_oe   <= 1'b1;
                                wr_valid <= 1'b1;
                                wr_byte  <= shreg;
                            end else if (addr_hit) begin
                                state  <= BUS_ADDR_ACK;
                                sda_oe <= 1'b1;
                                rw_q   <= shreg[0];
                                tx_q   <= status;
                            end else begin
                                state <= BUS_IDLE;
                            end
                        end
                    end
                    BUS_ADDR_ACK: if (scl_fall) begin
                        bitcnt <= '0;
                        if (rw_q) begin
                            state  <= BUS_RD;
                            sda_oe <= ~tx_q[7];
                        end else begin
                            state  <= BUS_WR;
                            sda_oe <= 1'b0;
                        end
                    end
                    BUS_WR_ACK: if (scl_fall) begin
                        state  <= BUS_WR;
                        sda_oe <= 1'b0;
                        bitcnt <= '0;
                    end
                    BUS_RD: if (scl_fall) begin
                        bitcnt <= bitcnt + 4'd1;
                        if (bitcnt == 4'd7) begin
                            state   <= BUS_RD_ACK;
                            sda_oe  <= 1'b0;
                            rd_done <= 1'b1;
                        end else begin
                            tx_q   <= {tx_q[6:0], 1'b0};
                            sda_oe <= ~tx_q[6];
                        end
                    end
                    BUS_RD_ACK: if (scl_fall) state <= BUS_IDLE;
                    default: state <= BUS_IDLE;
                endcase
            end
        end
    end

    // R1: the line is only pulled during an acknowledge slot or a read data bit
    assert_ack_window_R1: assert property (@(posedge clk) disable iff (rst)
        sda_oe |-> (state == BUS_ADDR_ACK || state == BUS_WR_ACK || state == BUS_RD));

    // R9: a read transfer never hands a byte to the register bank
    assert_no_write_in_read_R9: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> !rw_q);

    // R6: acknowledge of an address always follows an address byte phase
    assert_ack_after_addr_R6: assert property (@(posedge clk) disable iff (rst)
        (state == BUS_ADDR && scl_fall && bitcnt == 4'd8 && !bus_start && !bus_stop && !addr_hit)
        |=> state == BUS_IDLE && !sda_oe);
endmodule

// File: rtl/synth_reg_bank.sv
module synth_reg_bank
    import synth_i2c_pkg::*;
#(
    parameter int unsigned DIV_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              wr_valid,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              rd_done,
    output logic [DIV_W-1:0]  freq_q,
    output ctrl_t             ctrl_q,
    output logic [BYTE_W-1:0] ports_q,
    output logic              por_q
);
    localparam int unsigned HI_W = DIV_W - BYTE_W;

    seq_state_e      seq;
    logic [HI_W-1:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seq     <= SEQ_FIRST;
            hi_q    <= '0;
            freq_q  <= '0;
            ctrl_q  <= CTRL_RESET;
            ports_q <= '0;
            por_q   <= 1'b1;
        end else begin
            if (rd_done) por_q <= 1'b0;
            if (restart) begin
                seq <= SEQ_FIRST;
            end else if (wr_valid) begin
                case (seq)
                    SEQ_FIRST: begin
                        if (wr_byte[7]) begin
                            ctrl_q <= ctrl_t'(wr_byte[6:0]);
                            seq    <= SEQ_PB;
                        end else begin
                            hi_q <= wr_byte[HI_W-1:0];
                            seq  <= SEQ_DB2;
                        end
                    end
                    SEQ_DB2: begin
                        freq_q <= {hi_q, wr_byte};
                        seq    <= SEQ_CB;
                    end
                    SEQ_CB: begin
                        ctrl_q <= ctrl_t'(wr_byte[6:0]);
                        seq    <= SEQ_PB;
                    end
                    SEQ_PB: begin
                        ports_q <= wr_byte & PORT_MASK;
                        seq     <= SEQ_DONE;
                    end
                    default: seq <= SEQ_DONE;
                endcase
            end
        end
    end

    // R4: the divider word only moves on a completed write byte
    assert_freq_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |=> $stable(freq_q));

    // R10: once cleared, the power-on flag never returns without reset
    assert_por_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        !por_q |=> !por_q);

    // R8: after the port byte nothing more is committed
    assert_done_ignores_R8: assert property (@(posedge clk) disable iff (rst)
        (seq == SEQ_DONE && !restart) |=> $stable(ports_q) && $stable(ctrl_q) && $stable(freq_q));
endmodule

// File: rtl/synth_i2c_regif.sv
module synth_i2c_regif
    import synth_i2c_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DIV_W       = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic [1:0]       addr_sel,
    input  logic             lock_i,
    input  logic [2:0]       adc_code,
    output logic [DIV_W-1:0] freq_word,
    output logic             pump_high,
    output logic [2:0]       test_mode,
    output logic [1:0]       ref_ratio,
    output logic             tune_off,
    output logic [7:0]       port_out
);
    logic              sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic              wr_valid, rd_done, por;
    logic [BYTE_W-1:0] wr_byte, status;
    ctrl_t             ctrl;

    assign status = make_status(por, lock_i, adc_code);

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop)
    );

    i2c_byte_engine u_engine (
        .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop), .addr_sel(addr_sel), .status(status),
        .sda_oe(sda_oe), .wr_valid(wr_valid), .wr_byte(wr_byte), .rd_done(rd_done)
    );

    synth_reg_bank #(.DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst(rst), .restart(bus_start), .wr_valid(wr_valid), .wr_byte(wr_byte),
        .rd_done(rd_done), .freq_q(freq_word), .ctrl_q(ctrl), .ports_q(port_out), .por_q(por)
    );

    assign pump_high = ctrl.pump_high;
    assign test_mode = ctrl.test;
    assign ref_ratio = ctrl.ref_ratio;
    assign tune_off  = ctrl.tune_off;

    // R5: port bit 3 is never driven
    assert_p3_low_R5: assert property (@(posedge clk) disable iff (rst) port_out[3] == 1'b0);
endmodule

// File: tb/synth_i2c_regif_tb.sv
module synth_i2c_regif_tb;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic [1:0] addr_sel = 2'b01;
    logic lock_i = 1'b0;
    logic [2:0] adc_code = 3'd0;
    logic sda_oe, pump_high, tune_off;
    logic [14:0] freq_word;
    logic [2:0] test_mode;
    logic [1:0] ref_ratio;
    logic [7:0] port_out;
    logic sda_bus;
    int checks = 0;
    int errors = 0;

    assign sda_bus = m_sda & ~sda_oe;
    always #4 clk = ~clk;

    synth_i2c_regif u_dut (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .addr_sel(addr_sel), .lock_i(lock_i), .adc_code(adc_code), .freq_word(freq_word),
        .pump_high(pump_high), .test_mode(test_mode), .ref_ratio(ref_ratio),
        .tune_off(tune_off), .port_out(port_out)
    );

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(Q);
        scl = 1'b1;   wq(Q);
        m_sda = 1'b0; wq(Q);
        scl = 1'b0;   wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q);
        scl = 1'b1;   wq(Q);
        m_sda = 1'b1; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq(Q);
            scl = 1'b1;   wq(2*Q);
            scl = 1'b0;   wq(Q);
        end
        m_sda = 1'b1; wq(Q);
        scl = 1'b1;   wq(Q);
        ack = ~sda_bus;
        wq(Q);
        scl = 1'b0;   wq(Q);
    endtask

    task automatic recv_byte(input logic master_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q);
            scl = 1'b1; wq(Q);
            b[i] = sda_bus;
            wq(Q);
            scl = 1'b0;
        end
        wq(Q);
        m_sda = ~master_ack; wq(Q);
        scl = 1'b1; wq(2*Q);
        scl = 1'b0; wq(Q);
        m_sda = 1'b1;
    endtask

    task automatic write_seq(input logic [7:0] addr, input logic [7:0] d [], input string tag);
        logic ack;
        bus_start();
        send_byte(addr, ack);
        check({tag, " R1 addr ack"}, ack, 1'b1);
        foreach (d[i]) begin
            send_byte(d[i], ack);
            check({tag, " R1 data ack"}, ack, 1'b1);
        end
        bus_stop();
    endtask

    task automatic t_reset();
        check("R7 freq", freq_word, 0);
        check("R7 pump", pump_high, 0);
        check("R7 test", test_mode, 3'b001);
        check("R7 ref", ref_ratio, 0);
        check("R7 tune_off", tune_off, 0);
        check("R7 ports", port_out, 0);
        check("R7 sda_oe", sda_oe, 0);
    endtask

    task automatic t_full_write();
        addr_sel = 2'b01;
        write_seq(8'hC4, '{8'h12, 8'h34, 8'hD6, 8'hFF}, "full");
        check("R2 freq", freq_word, 15'h1234);
        check("R4 pump after DB2", pump_high, 1);
        check("R4 test", test_mode, 3'b010);
        check("R4 ref", ref_ratio, 2'b11);
        check("R4 tune_off", tune_off, 0);
        check("R5 ports bit3 masked", port_out, 8'hF7);
    endtask

    task automatic t_db1_only();
        write_seq(8'hC4, '{8'h05}, "db1");
        check("R4 freq held after DB1", freq_word, 15'h1234);
    endtask

    task automatic t_ctrl_path();
        write_seq(8'hC4, '{8'h81, 8'h5A}, "ctrl");
        check("R3 pump", pump_high, 0);
        check("R3 test", test_mode, 3'b000);
        check("R3 tune_off", tune_off, 1);
        check("R3 freq untouched", freq_word, 15'h1234);
        check("R5 ports", port_out, 8'h52);
    endtask

    task automatic t_foreign();
        logic ack;
        addr_sel = 2'b01;
        bus_start();
        send_byte(8'hC6, ack);
        check("R6 foreign nack", ack, 0);
        send_byte(8'h80, ack);
        send_byte(8'h00, ack);
        bus_stop();
        check("R6 foreign ports", port_out, 8'h52);
        check("R6 foreign ctrl", tune_off, 1);
    endtask

    task automatic t_general();
        addr_sel = 2'b10;
        write_seq(8'hC2, '{8'h0F, 8'hAB}, "general");
        check("R6 general freq", freq_word, 15'h0FAB);
        write_seq(8'hC6, '{8'hC0, 8'h11, 8'h22, 8'h33}, "extra");
        check("R6 sel10 ctrl pump", pump_high, 1);
        check("R8 extra ignored ports", port_out, 8'h11);
        check("R8 extra ignored tune", tune_off, 0);
    endtask

    task automatic t_read();
        logic ack;
        logic [7:0] b;
        addr_sel = 2'b01;
        lock_i = 1'b1; adc_code = 3'd3;
        bus_start();
        send_byte(8'hC5, ack);
        check("R1 read addr ack", ack, 1);
        recv_byte(1'b0, b);
        bus_stop();
        check("R9 R10 status first", b, 8'hF3);
        lock_i = 1'b0; adc_code = 3'd6;
        bus_start();
        send_byte(8'hC3, ack);
        check("R6 general read ack", ack, 1);
        recv_byte(1'b0, b);
        bus_stop();
        check("R10 R11 status second", b, 8'h34);
    endtask

    task automatic t_restart();
        logic ack;
        addr_sel = 2'b01;
        bus_start();
        send_byte(8'hC4, ack);
        send_byte(8'h07, ack);
        bus_start();
        send_byte(8'hC4, ack);
        send_byte(8'h9F, ack);
        send_byte(8'h01, ack);
        bus_stop();
        check("R12 freq kept", freq_word, 15'h0FAB);
        check("R12 test", test_mode, 3'b011);
        check("R12 ref", ref_ratio, 2'b11);
        check("R12 tune_off", tune_off, 1);
        check("R12 ports", port_out, 8'h01);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wq(5);
        rst = 1'b0;
        wq(5);
        t_reset();
        t_full_write();
        t_db1_only();
        t_ctrl_path();
        t_foreign();
        t_general();
        t_read();
        t_restart();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule